// File: doc/BRIEF.md
# Two-Level Weighted Bus Arbiter

This block arbitrates a shared parallel bus among seven masters. Index 0 is the on-chip master and indices 1 to 6 are external masters. Every master has its own request and grant line. A configuration mask puts each request into a high or a low priority group. Inside each group the masters are served round-robin. Between the groups the arbiter uses one of three rules: strict priority, a weighted alternation driven by a reloadable counter, or reversed priority.

Grants change only while the bus is idle. In this design, busy means FRAME or IRDY is high. When no master is requesting, the grant stays parked on a master. After a grant, a watchdog waits for the granted master to start its cycle. If the master never starts, the watchdog removes the grant and pulses an interrupt.

The controller is a four-state machine:
- ARB: evaluates requests or parking while the bus is idle.
- GAP: holds the grant vector at zero for one cycle, then drives the new grant.
- WAIT: the granted master has not yet raised FRAME.
- BUSY: a transaction is in progress.

Transitions:
- ARB→BUSY: the bus is busy.
- ARB→GAP: a different master wins, the grant vector is zero, or the parking target changes.
- ARB→WAIT: the current master wins again.
- GAP→WAIT: the new grant answers a request.
- GAP→ARB: the new grant is only a parking move.
- WAIT→BUSY: FRAME is seen.
- WAIT→ARB: the wait times out.
- BUSY→ARB: the bus returns to idle.

Top module: `wrr_bus_arbiter`

## Requirements
- R1: `gnt_o` is one-hot or zero. Bit i grants master i, and bit 0 is the internal master. While reset is held and right after reset, `gnt_o` = 7'b0000001.
- R2: A request whose `hi_prio_i` bit is 1 is in the high group, and a 0 bit puts it in the low group. With `wrr_en_i` = 0, a low-group master is granted only when no high-group request is pending.
- R3: Inside a group, the search for the next grant starts at the index just after the group's last granted member and wraps from 6 to 0. After reset, each group's search starts at index 0.
- R4: With `wrr_en_i` = 1 and a nonzero `weight_i` W, and requests pending in both groups, the arbiter gives W high-group grants and then one low-group grant, and repeats. A low-group grant reloads the high-grant count to W.
- R5: With `wrr_en_i` = 1 and `weight_i` = 0, the order is reversed: a high-group master is granted only when no low-group request is pending.
- R6: Arbitration happens on an edge where the FSM is in ARB and the bus is idle.
  - If a different master wins, `gnt_o` is zero after that edge and shows the winner after the next edge.
  - If the master already granted wins again, its grant stays up with no zero cycle.
- R7: With a nonzero `broken_lim_i` B, suppose the granted master does not raise FRAME. Then its grant is visible for exactly B idle cycles. On the next edge `gnt_o` goes to zero and `broken_irq_o` is high for exactly one cycle. B = 0 disables the timeout.
- R8: The timeout count does not advance while IRDY is high without FRAME.
- R9: With no requests pending, the grant stays on the last granted master. If that master's `park_dis_i` bit is set, the grant moves through one zero cycle to the internal master. This also covers the case where every bit of `park_dis_i` is set.
- R10: While a transaction is in progress (state BUSY), `gnt_o` does not change, even when new requests arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 7 | Request per master, bit 0 is the internal master |
| frame_i | input | 1 | High while a master drives FRAME (address or data phase active) |
| irdy_i | input | 1 | High while IRDY is asserted on the bus |
| wrr_en_i | input | 1 | Enables weighted alternation between the groups |
| hi_prio_i | input | 7 | Group mask, 1 means high priority |
| weight_i | input | 8 | Preset for the high-grant counter |
| broken_lim_i | input | 4 | Idle cycles allowed before the grant is withdrawn, 0 disables |
| park_dis_i | input | 7 | Per-master parking disable |
| gnt_o | output | 7 | One-hot grant |
| broken_irq_o | output | 1 | One-cycle pulse when a grant is withdrawn |

## Verification
Some properties are checked on every cycle:
- The grant vector stays one-hot or zero.
- Every change between two nonzero grants passes through a zero cycle.
- The grant is frozen while the FSM is in BUSY.
- The interrupt lasts a single cycle and coincides with a zero grant.
- The weighted controller gives up its low-group turn once a low-group master is served.

Other behaviours can only be shown by the bench's scenarios:
- the actual sequences of masters under the three inter-group rules;
- the round-robin rotation;
- the exact timeout cycle and its pause during IRDY;
- the parking targets.

// File: rtl/wrr_arb_pkg.sv
package wrr_arb_pkg;
    typedef enum logic [1:0] {
        ST_ARB  = 2'd0,
        ST_GAP  = 2'd1,
        ST_WAIT = 2'd2,
        ST_BUSY = 2'd3
    } arb_state_e;
endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int N  = 7,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  cand_i,
    input  logic [IW-1:0] last_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    int   pos;
    logic found;

    always_comb begin
        any_o = |cand_i;
        idx_o = last_i;
        found = 1'b0;
        pos   = 0;
        for (int k = 1; k <= N; k++) begin
            pos = (int'(last_i) + k) % N;
            if (!found && cand_i[pos]) begin
                idx_o = pos[IW-1:0];
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/arb_weight_ctr.sv
module arb_weight_ctr #(
    parameter int WW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic [WW-1:0] weight_i,
    input  logic          hi_pend_i,
    input  logic          lo_pend_i,
    input  logic          fire_i,
    output logic          pick_hi_o
);
    logic [WW-1:0] cnt_q;
    logic [WW-1:0] eff;
    logic          lo_turn_q;

    assign eff = (cnt_q == '0) ? weight_i : cnt_q;

    always_comb begin
        if (!en_i)
            pick_hi_o = hi_pend_i;
        else if (weight_i == '0)
            pick_hi_o = hi_pend_i && !lo_pend_i;
        else
            pick_hi_o = hi_pend_i && !(lo_turn_q && lo_pend_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            lo_turn_q <= 1'b0;
        end else if (fire_i) begin
            if (pick_hi_o) begin
                if (eff <= WW'(1)) begin
                    cnt_q     <= weight_i;
                    lo_turn_q <= 1'b1;
                end else begin
                    cnt_q     <= eff - WW'(1);
                end
            end else begin
                cnt_q     <= weight_i;
                lo_turn_q <= 1'b0;
            end
        end
    end

    // R4: a served low turn is consumed
    p_lo_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && en_i && weight_i != '0 && lo_turn_q && lo_pend_i) |=> !lo_turn_q);
endmodule

// File: rtl/wrr_bus_arbiter.sv
module wrr_bus_arbiter
    import wrr_arb_pkg::*;
#(
    parameter int NUM_M = 7,
    parameter int WGT_W = 8,
    parameter int BRK_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM_M-1:0] req_i,
    input  logic             frame_i,
    input  logic             irdy_i,
    input  logic             wrr_en_i,
    input  logic [NUM_M-1:0] hi_prio_i,
    input  logic [WGT_W-1:0] weight_i,
    input  logic [BRK_W-1:0] broken_lim_i,
    input  logic [NUM_M-1:0] park_dis_i,
    output logic [NUM_M-1:0] gnt_o,
    output logic             broken_irq_o
);
    localparam int IW = $clog2(NUM_M);

    arb_state_e     state_q, state_d;
    logic [IW-1:0]  cur_idx_q, pend_idx_q, win_idx, park_idx;
    logic           pend_req_q;
    logic [BRK_W-1:0] wait_cnt_q;
    logic [IW-1:0]  last_q   [2];
    logic [IW-1:0]  pick_idx [2];
    logic [NUM_M-1:0] grp_cand [2];
    logic [1:0]     grp_any;
    logic           bus_busy, any_req, fire, pick_hi, timeout, change;

    assign bus_busy    = frame_i | irdy_i;
    assign any_req     = |req_i;
    assign grp_cand[0] = req_i & ~hi_prio_i;
    assign grp_cand[1] = req_i & hi_prio_i;

    for (genvar g = 0; g < 2; g++) begin : g_grp
        arb_rr_pick #(.N(NUM_M), .IW(IW)) u_pick (
            .cand_i (grp_cand[g]),
            .last_i (last_q[g]),
            .any_o  (grp_any[g]),
            .idx_o  (pick_idx[g])
        );
    end

    arb_weight_ctr #(.WW(WGT_W)) u_wgt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (wrr_en_i),
        .weight_i  (weight_i),
        .hi_pend_i (grp_any[1]),
        .lo_pend_i (grp_any[0]),
        .fire_i    (fire),
        .pick_hi_o (pick_hi)
    );

    assign win_idx  = pick_hi ? pick_idx[1] : pick_idx[0];
    assign park_idx = park_dis_i[cur_idx_q] ? IW'(0) : cur_idx_q;
    assign fire     = (state_q == ST_ARB) && !bus_busy && any_req;
    assign change   = any_req ? ((win_idx != cur_idx_q) || (gnt_o == '0))
                              : ((park_idx != cur_idx_q) || (gnt_o == '0));
    assign timeout  = (broken_lim_i != '0) && !bus_busy &&
                      (({1'b0, wait_cnt_q} + (BRK_W+1)'(1)) == {1'b0, broken_lim_i});

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARB: begin
                if (bus_busy)                state_d = ST_BUSY;
                else if (change)             state_d = ST_GAP;
                else if (any_req)            state_d = ST_WAIT;
            end
            ST_GAP:  state_d = pend_req_q ? ST_WAIT : ST_ARB;
            ST_WAIT: begin
                if (frame_i)                 state_d = ST_BUSY;
                else if (timeout)            state_d = ST_ARB;
            end
            ST_BUSY: if (!bus_busy)          state_d = ST_ARB;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ARB;
        else        state_q <= state_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gnt_o        <= NUM_M'(1);
            broken_irq_o <= 1'b0;
            cur_idx_q    <= '0;
            pend_idx_q   <= '0;
            pend_req_q   <= 1'b0;
            wait_cnt_q   <= '0;
            last_q[0]    <= IW'(NUM_M-1);
            last_q[1]    <= IW'(NUM_M-1);
        end else begin
            broken_irq_o <= 1'b0;
            unique case (state_q)
                ST_ARB: begin
                    if (!bus_busy) begin
                        if (any_req) begin
                            last_q[pick_hi] <= win_idx;
                            wait_cnt_q      <= '0;
                            if (change) begin
                                gnt_o      <= '0;
                                pend_idx_q <= win_idx;
                                pend_req_q <= 1'b1;
                            end
                        end else if (change) begin
                            gnt_o      <= '0;
                            pend_idx_q <= park_idx;
                            pend_req_q <= 1'b0;
                        end
                    end
                end
                ST_GAP: begin
                    gnt_o      <= NUM_M'(1) << pend_idx_q;
                    cur_idx_q  <= pend_idx_q;
                    wait_cnt_q <= '0;
                end
                ST_WAIT: begin
                    if (!frame_i && timeout) begin
                        gnt_o        <= '0;
                        broken_irq_o <= 1'b1;
                    end else if (!bus_busy) begin
                        wait_cnt_q <= wait_cnt_q + BRK_W'(1);
                    end
                end
                ST_BUSY: ;
            endcase
        end
    end

    // R1: at most one grant
    p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));
    // R6: grant moves between masters only through a zero cycle
    p_gap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0 && $past(gnt_o) != '0) |-> gnt_o == $past(gnt_o));
    // R7: interrupt is a single-cycle pulse
    p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        broken_irq_o |=> !broken_irq_o);
    // R7: interrupt only with the grant withdrawn
    p_irq_gnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        broken_irq_o |-> gnt_o == '0);
    // R10: grant frozen during a transaction
    p_hold_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY) |=> $stable(gnt_o));
endmodule

// File: tb/wrr_bus_arbiter_test.sv
module wrr_bus_arbiter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] req = '0;
    logic       frame = 1'b0, irdy = 1'b0, wen = 1'b0;
    logic [6:0] hi = '0, pdis = '0;
    logic [7:0] wgt = '0;
    logic [3:0] blim = '0;
    logic [6:0] gnt;
    logic       irq;
    int         checks = 0, errors = 0;
    logic       done = 1'b0;

    always #5 clk = ~clk;

    wrr_bus_arbiter uut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .frame_i(frame), .irdy_i(irdy),
        .wrr_en_i(wen), .hi_prio_i(hi), .weight_i(wgt), .broken_lim_i(blim),
        .park_dis_i(pdis), .gnt_o(gnt), .broken_irq_o(irq)
    );

    // {req, hi, wrr_en, weight, expected first grant}
    localparam logic [29:0] VEC [0:5] = '{
        {7'b0000110, 7'b0000010, 1'b0, 8'd0, 7'b0000010}, // R2 high wins
        {7'b0000110, 7'b0000010, 1'b1, 8'd0, 7'b0000100}, // R5 reversed
        {7'b1000001, 7'b0000000, 1'b0, 8'd0, 7'b0000001}, // R3 search from 0
        {7'b1000000, 7'b1000000, 1'b0, 8'd0, 7'b1000000}, // R3 top index
        {7'b0110000, 7'b0100000, 1'b1, 8'd3, 7'b0100000}, // R4 high first
        {7'b0000000, 7'b0000000, 1'b0, 8'd0, 7'b0000001}  // R9 parked internal
    };

    task automatic chk(input string tag, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; frame = 1'b0; irdy = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // one transaction, new request vector applied as the bus goes idle
    task automatic txn(input logic [6:0] nreq, output logic [6:0] mid, output logic [6:0] fin);
        frame = 1'b1;
        repeat (2) @(negedge clk);
        frame = 1'b0; req = nreq;
        repeat (2) @(negedge clk);
        mid = gnt;
        @(negedge clk);
        fin = gnt;
    endtask

    initial begin
        logic [6:0] m, f;
        @(negedge clk);
        chk("R1 reset grant", gnt, 7'b0000001);
        chk("R7 reset irq", {6'd0, irq}, 7'd0);

        for (int i = 0; i < 6; i++) begin
            {req, hi, wen, wgt} = VEC[i][29:7];
            pdis = '0; blim = '0;
            do_reset();
            repeat (2) @(negedge clk);
            chk($sformatf("R2/R3/R4/R5/R9 table %0d", i), gnt, VEC[i][6:0]);
        end

        // R4 weighted sequence, weight 2
        hi = 7'b0000010; wen = 1'b1; wgt = 8'd2; req = 7'b0000110;
        do_reset(); repeat (2) @(negedge clk);
        chk("R4 seq0", gnt, 7'b0000010);
        txn(req, m, f); chk("R4 seq1", f, 7'b0000010);
        txn(req, m, f); chk("R4 seq2", f, 7'b0000100);
        txn(req, m, f); chk("R4 seq3", f, 7'b0000010);
        txn(req, m, f); chk("R4 seq4", f, 7'b0000010);
        txn(req, m, f); chk("R4 seq5", f, 7'b0000100);

        // R5 reversed stays low
        wgt = 8'd0; do_reset(); repeat (2) @(negedge clk);
        txn(req, m, f); chk("R5 again low", f, 7'b0000100);

        // R2 strict and R6 no gap on re-grant
        wen = 1'b0; do_reset(); repeat (2) @(negedge clk);
        txn(req, m, f);
        chk("R6 same master no gap", m, 7'b0000010);
        chk("R2 strict high", f, 7'b0000010);

        // R3 rotation and R6 gap
        hi = 7'b0000110; do_reset(); repeat (2) @(negedge clk);
        chk("R3 first", gnt, 7'b0000010);
        txn(req, m, f);
        chk("R6 zero gap", m, 7'b0000000);
        chk("R3 rotate", f, 7'b0000100);
        txn(req, m, f); chk("R3 wrap", f, 7'b0000010);

        // R10 hold during transaction
        hi = 7'b0000010; req = 7'b0000100; do_reset(); repeat (2) @(negedge clk);
        chk("R2 low alone", gnt, 7'b0000100);
        frame = 1'b1; @(negedge clk); req = 7'b0000110;
        repeat (3) @(negedge clk);
        chk("R10 held busy", gnt, 7'b0000100);
        frame = 1'b0; repeat (3) @(negedge clk);
        chk("R2 high after busy", gnt, 7'b0000010);

        // R7 timeout
        hi = '0; req = 7'b0001000; blim = 4'd3; do_reset(); repeat (2) @(negedge clk);
        chk("R7 granted", gnt, 7'b0001000);
        repeat (2) @(negedge clk);
        chk("R7 still granted", {gnt[6:1], irq}, 7'b0001000);
        @(negedge clk);
        chk("R7 withdrawn", gnt, 7'b0000000);
        chk("R7 irq", {6'd0, irq}, 7'd1);
        @(negedge clk);
        chk("R7 irq pulse ends", {6'd0, irq}, 7'd0);

        // R7 disabled
        blim = 4'd0; do_reset(); repeat (22) @(negedge clk);
        chk("R7 disabled", {gnt[6:1], irq}, 7'b0001000);

        // R8 pause while IRDY
        blim = 4'd3; do_reset(); repeat (2) @(negedge clk);
        irdy = 1'b1; repeat (5) @(negedge clk);
        chk("R8 paused", {gnt[6:1], irq}, 7'b0001000);
        irdy = 1'b0; repeat (2) @(negedge clk);
        chk("R8 resumed", gnt, 7'b0001000);
        @(negedge clk);
        chk("R8 expiry", gnt, 7'b0000000);

        // R9 parking
        blim = '0; req = 7'b0010000; pdis = '0; do_reset(); repeat (2) @(negedge clk);
        txn(7'b0, m, f); repeat (4) @(negedge clk);
        chk("R9 park last", gnt, 7'b0010000);
        pdis = 7'b0010000; req = 7'b0010000; do_reset(); repeat (2) @(negedge clk);
        txn(7'b0, m, f);
        chk("R9 disabled gap", m, 7'b0000000);
        chk("R9 park internal", f, 7'b0000001);
        pdis = 7'b1111111; req = 7'b0100000; do_reset(); repeat (2) @(negedge clk);
        txn(7'b0, m, f);
        chk("R9 all disabled", f, 7'b0000001);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule